// File: doc/BRIEF.md
# Double-Buffered Transmit Signaling Bank

This block keeps one signaling bit for each payload block of a framed DSL transmitter. It has two register banks. A host processor writes new bits into a staging bank. The transmit framer reads a separate live bank, one bit per block, through a block index. A load strobe copies the whole staging bank into the live bank in one clock edge. The bits being transmitted therefore never show a half-written set, whatever the host writes during an interval.

The strobe always fires on the frame-start pulse of the 6 ms DSL frame. A 2-bit rate field can also make it fire part-way through the frame, giving an update period of 3, 2 or 1 ms. The sub-frame points are counted from a 1 ms tick input, and the count restarts at every frame start. The strobe also sets a sticky host interrupt flag, which tells the host that a new write window has opened. The host clears the flag by writing 1 to the clear input.

Top module: `sig_dbuf_bank`

## Requirements
- R1: After reset, every live-bank bit is 0, `irq` is 0 and `s_bit` is 0.
- R2: A host write (`host_we`=1, `host_addr` 0 to 47) changes only the staging bank. The live bank, and so `s_bit`, keeps its value until the next load strobe.
- R3: On a load strobe, all 48 staging bits are copied to the live bank on the same clock edge.
- R4: A `frame_start` pulse always causes a load strobe, whatever the rate setting, and restarts the sub-frame count at zero.
- R5: With `rate_sel`=00, `ms_tick` pulses cause no strobe. The live bank changes only at frame start.
- R6: With `rate_sel`=01, a strobe fires on the 3rd `ms_tick` after frame start. With 10, it fires on the 2nd and 4th. With 11, it fires on each of the 1st to 5th.
- R7: If a host write and a load strobe happen in the same cycle, the transfer uses the staging value from before the write. The written value reaches the live bank at the following strobe.
- R8: Every load strobe sets `irq`. `irq` stays set until a cycle with `irq_clr`=1 and no strobe clears it. When a strobe and a clear happen in the same cycle, `irq` ends up set.
- R9: The read is registered. `s_bit` shows, one clock after the edge where `rd_idx` is sampled, the live bit of block `rd_idx`. An index of 48 to 63 reads 0.
- R10: A host write with `host_addr` of 48 to 63 changes no register.
- R11: Once the 6th `ms_tick` after a frame start has been reached without a new `frame_start`, `ms_tick` causes no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each 6 ms frame |
| ms_tick | input | 1 | One-cycle pulse every 1 ms |
| rate_sel | input | 2 | Update period: 00 = 6 ms, 01 = 3 ms, 10 = 2 ms, 11 = 1 ms |
| host_we | input | 1 | Host write enable for the staging bank |
| host_addr | input | 6 | Block index of the host write |
| host_wdata | input | 1 | Signaling bit to write |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| irq | output | 1 | Sticky load-strobe interrupt |
| rd_idx | input | 6 | Block index read by the framer |
| s_bit | output | 1 | Registered signaling bit of the indexed block |

## Verification
Some properties are checked by assertions on every cycle:
- The live bank holds its value in any cycle without a strobe.
- A strobe copies the previous staging bank exactly.
- An out-of-range write leaves the staging bank untouched.
- Rate 00 never strobes without a frame start.
- The interrupt flag sets on a frame start, stays set until it is cleared, and clears on `irq_clr` when no strobe comes.

Other behaviour can only be shown by the bench's scenarios:
- The exact tick positions of sub-frame strobes at each rate.
- A write that meets a strobe in the same cycle, and the strobe that follows it.
- The one-cycle latency of the indexed read.

// File: rtl/sig_dbuf_pkg.sv
package sig_dbuf_pkg;

    typedef enum logic [1:0] {
        RATE_FRAME = 2'b00,
        RATE_HALF  = 2'b01,
        RATE_THIRD = 2'b10,
        RATE_MS    = 2'b11
    } rate_e;

    // Number of 1 ms ticks between strobes for a given rate and frame length
    function automatic int unsigned rate_period(rate_e r, int unsigned frame_ms);
        case (r)
            RATE_HALF:  return frame_ms / 2;
            RATE_THIRD: return frame_ms / 3;
            RATE_MS:    return 1;
            default:    return frame_ms;
        endcase
    endfunction

endpackage

// File: rtl/sig_strobe_gen.sv
module sig_strobe_gen
    import sig_dbuf_pkg::*;
#(
    parameter int unsigned FRAME_MS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       ms_tick,
    input  logic [1:0] rate_sel,
    output logic       load_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_MS + 1);
    localparam logic [CNT_W-1:0] FRAME_LIM = CNT_W'(FRAME_MS);

    typedef struct packed {
        logic [CNT_W-1:0] ms;
        logic [CNT_W-1:0] phase;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] ms_nx;
    logic [CNT_W-1:0] ph_nx;

    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        period = CNT_W'(rate_period(rate_e'(rate_sel), FRAME_MS));
        ms_nx  = st_q.ms + 1'b1;
        ph_nx  = st_q.phase + 1'b1;
        if (frame_start) begin
            st_d.ms    = '0;
            st_d.phase = '0;
            load_o     = 1'b1;
        end else if (ms_tick && (st_q.ms < FRAME_LIM)) begin
            st_d.ms = ms_nx;
            if (ph_nx >= period) begin
                st_d.phase = '0;
                load_o     = (ms_nx < FRAME_LIM);
            end else begin
                st_d.phase = ph_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the frame rate strobes only at frame start
    assert_rate0_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_sel == 2'b00) && !frame_start) |-> !load_o);

    // R4: frame start restarts the sub-frame count
    assert_frame_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.ms == '0));

endmodule

// File: rtl/sig_bank.sv
module sig_bank #(
    parameter int unsigned NUM_BLK = 48,
    parameter int unsigned IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic             wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             s_bit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLK - 1);

    typedef struct packed {
        logic [NUM_BLK-1:0] inb;
        logic [NUM_BLK-1:0] outb;
        logic               sbit;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // transfer reads the pre-write staging value
        if (load) st_d.outb = st_q.inb;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (we && (waddr == IDX_W'(i))) st_d.inb[i] = wdata;
        end
        st_d.sbit = 1'b0;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (rd_idx == IDX_W'(i)) st_d.sbit = st_q.outb[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_bit = st_q.sbit;

    // R2: the live bank holds between strobes
    assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.outb));

    // R3: a strobe copies the whole staging bank
    assert_bank_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.outb == $past(st_q.inb)));

    // R10: an out-of-range write touches nothing
    assert_oob_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr > LAST_IDX)) |=> $stable(st_q.inb));

endmodule

// File: rtl/sig_dbuf_bank.sv
module sig_dbuf_bank
    import sig_dbuf_pkg::*;
#(
    parameter int unsigned NUM_BLK  = 48,
    parameter int unsigned FRAME_MS = 6,
    parameter int unsigned IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             ms_tick,
    input  logic [1:0]       rate_sel,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_addr,
    input  logic             host_wdata,
    input  logic             irq_clr,
    output logic             irq,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             s_bit
);
    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    load;

    sig_strobe_gen #(.FRAME_MS(FRAME_MS)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .ms_tick     (ms_tick),
        .rate_sel    (rate_sel),
        .load_o      (load)
    );

    sig_bank #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .we     (host_we),
        .waddr  (host_addr),
        .wdata  (host_wdata),
        .rd_idx (rd_idx),
        .s_bit  (s_bit)
    );

    always_comb begin
        st_d = st_q;
        if (load)         st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R4: a frame start always raises the interrupt
    assert_frame_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> irq);

    // R8: the flag is sticky until cleared
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R8: a clear without a strobe takes effect
    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !frame_start && !ms_tick) |=> !irq);

endmodule

// File: tb/sig_dbuf_bank_bench.sv
module sig_dbuf_bank_bench;
    localparam int NB = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic       host_wdata = 1'b0;
    logic       irq_clr = 1'b0;
    logic       irq;
    logic [5:0] rd_idx = '0;
    logic       s_bit;

    always #5 clk = ~clk;

    sig_dbuf_bank u_sig_dbuf_bank (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ms_tick(ms_tick),
        .rate_sel(rate_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .irq_clr(irq_clr), .irq(irq),
        .rd_idx(rd_idx), .s_bit(s_bit)
    );

    typedef struct {
        int    cyc;
        int    idx;
        bit    exp;
        string tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    int  n_chk = 0;
    int  n_err = 0;
    int  cyc_now = 0;
    bit  m_in[NB];
    bit  m_out[NB];
    bit  m_irq = 1'b0;
    int  m_ms = 0;

    always @(posedge clk) cyc_now <= cyc_now + 1;

    function automatic void chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endfunction

    // monitor: compares registered read results one cycle after the request
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc < cyc_now) begin
            rd_item_t it;
            it = sb_q.pop_front();
            chk(s_bit == it.exp, $sformatf("%s blk %0d", it.tag, it.idx), s_bit, it.exp);
        end
    end

    function automatic int period(logic [1:0] r);
        case (r)
            2'b01:   return 3;
            2'b10:   return 2;
            2'b11:   return 1;
            default: return 6;
        endcase
    endfunction

    // one cycle of stimulus plus model update and interrupt check
    task automatic do_cyc(bit fs, bit tk, bit we, int addr, bit data, bit clr, string tag);
        bit strobe = 1'b0;
        frame_start = fs; ms_tick = tk; host_we = we;
        host_addr = 6'(addr); host_wdata = data; irq_clr = clr;
        if (fs) begin
            m_ms = 0; strobe = 1'b1;
        end else if (tk && m_ms < 6) begin
            m_ms++;
            if (m_ms < 6 && (m_ms % period(rate_sel)) == 0) strobe = 1'b1;
        end
        if (strobe) for (int i = 0; i < NB; i++) m_out[i] = m_in[i];
        if (we && addr < NB) m_in[addr] = data;
        if (strobe) m_irq = 1'b1;
        else if (clr) m_irq = 1'b0;
        @(negedge clk);
        frame_start = 0; ms_tick = 0; host_we = 0; irq_clr = 0;
        chk(irq == m_irq, {tag, " irq"}, irq, m_irq);
    endtask

    task automatic rd(int idx, string tag);
        rd_item_t it;
        rd_idx = 6'(idx);
        it.cyc = cyc_now; it.idx = idx; it.tag = tag;
        it.exp = (idx < NB) ? m_out[idx] : 1'b0;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd_all(string tag);
        for (int i = 0; i < NB; i++) rd(i, tag);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_in[i] = 0; m_out[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
        chk(s_bit == 1'b0, "R1 reset s_bit", s_bit, 0);
        rd_all("R1 reset bank");

        // R2: staging writes are invisible before a strobe
        for (int i = 0; i < NB; i++) do_cyc(0, 0, 1, i, (i % 3) == 0, 0, "R2 write");
        rd_all("R2 live unchanged");

        // R3/R4: frame start copies all blocks and raises irq
        do_cyc(1, 0, 0, 0, 0, 0, "R4 frame strobe");
        rd_all("R3 bulk copy");
        do_cyc(0, 0, 0, 0, 0, 1, "R8 clear");

        // R5/R6/R11: sub-frame strobe positions per rate
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            do_cyc(1, 0, 0, 0, 0, 0, "R4 frame");
            do_cyc(0, 0, 0, 0, 0, 1, "R8 clear");
            for (int t = 1; t <= 7; t++) begin
                do_cyc(0, 0, 1, 5, ~m_in[5], 0, "R2 toggle");
                do_cyc(0, 1, 0, 0, 0, 0, (r == 0) ? "R5 tick" : (t >= 6 ? "R11 tick" : "R6 tick"));
                rd(5, (r == 0) ? "R5 live" : "R6 live");
                do_cyc(0, 0, 0, 0, 0, 1, "R8 clear");
            end
        end
        rate_sel = 2'b00;

        // R7: write meets strobe
        do_cyc(0, 0, 1, 7, 0, 0, "R7 prep");
        do_cyc(1, 0, 0, 0, 0, 0, "R7 frame");
        do_cyc(1, 0, 1, 7, 1, 0, "R7 collide");
        rd(7, "R7 old value");
        do_cyc(1, 0, 0, 0, 0, 0, "R7 next frame");
        rd(7, "R7 new value");

        // R8: strobe wins over clear; flag sticky
        do_cyc(0, 0, 0, 0, 0, 0, "R8 sticky");
        do_cyc(1, 0, 0, 0, 0, 1, "R8 set wins");
        do_cyc(0, 0, 0, 0, 0, 1, "R8 clear");
        do_cyc(0, 0, 0, 0, 0, 0, "R8 stays clear");

        // R10: out-of-range writes ignored
        for (int i = 0; i < NB; i++) do_cyc(0, 0, 1, i, 1'b0, 0, "R10 zero");
        do_cyc(0, 0, 1, 50, 1, 0, "R10 oob");
        do_cyc(0, 0, 1, 63, 1, 0, "R10 oob");
        do_cyc(1, 0, 0, 0, 0, 0, "R10 frame");
        rd_all("R10 bank zero");

        // R9: out-of-range read and back-to-back index changes
        for (int i = 0; i < NB; i++) do_cyc(0, 0, 1, i, i[0], 0, "R9 pattern");
        do_cyc(1, 0, 0, 0, 0, 0, "R9 frame");
        rd(60, "R9 oob read");
        rd(3, "R9 odd");
        rd(4, "R9 even");
        rd(48, "R9 oob read");
        rd(47, "R9 last");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule